// File: doc/BRIEF.md
# Supervisory Reset Generator with Delay

This block produces the active-low reset for a microcontroller from a set of supply-monitor flags that arrive already digitised. It watches whether the regulated output is alive (at or above about 1 V), whether it sits above the reset threshold, and whether the input supply has fallen into undervoltage. When the supply is not good it holds reset low. Once the supply becomes good it keeps reset low for a power-on delay and then releases it. A release strobe tells a companion watchdog that the processor has just come out of reset.

Brief dips of the supply are filtered by a reaction-time counter, so that a glitch does not reset the processor. An input undervoltage trips the same path even while the output is still above its threshold. Two static mode pins choose a short (fast) or long (slow) release delay. A watchdog request pulls reset low at once and runs the whole delay again. All timing is counted in strobes of an external timebase tick, so one parameter set covers any clock frequency. A separate drive-enable output models the open-drain stage switching to high impedance when the output supply has collapsed.

Top module: `rstgen_supervisor`

## Requirements
- R1: In the cycle after synchronous reset, `rst_n_out`, `release_pulse` and `rst_drive_en` are all 0.
- R2: While reset is low and the supply is bad (`vout_ok` = 0 or `vin_low` = 1), reset stays low on the next cycle.
- R3: With mode pins {`mode_a`,`mode_b`} = 00 (fast), reset rises exactly FAST_TICKS+1 cycles after the supply becomes good when `tick` is high every cycle: one cycle to start the delay, then FAST_TICKS ticks.
- R4: With mode pins 01, 10 or 11 (slow), the same delay uses SLOW_TICKS ticks, so release comes SLOW_TICKS+1 cycles after the delay starts.
- R5: A bad-supply interval seen on at most REACT_TICKS clock edges with a tick leaves a released reset high. The filter count goes back to zero whenever the supply is good again, so separate short dips do not add up.
- R6: A bad supply that lasts longer than REACT_TICKS ticks drives reset low. With a tick every cycle, reset falls REACT_TICKS+1 cycles after the output drops below threshold.
- R7: `vin_low` = 1 trips reset through the same reaction filter even while `vout_ok` = 1.
- R8: A watchdog request (`wd_req` = 1) while reset is high drives reset low on the next cycle. The full power-on delay then runs again before release. A request during the delay restarts the delay.
- R9: `release_pulse` is high for exactly one cycle, in the same cycle that `rst_n_out` rises.
- R10: `rst_drive_en` follows `vout_live` one cycle later. `vout_live` = 0 forces reset low on the next cycle.
- R11: If the supply goes bad during the delay, even for a single cycle, reset stays low and the delay starts again from zero once the supply is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe; all delays count these |
| vout_live | input | 1 | Output supply at least about 1 V |
| vout_ok | input | 1 | Output supply above the reset threshold |
| vin_low | input | 1 | Input supply in undervoltage |
| wd_req | input | 1 | Reset request from the watchdog |
| mode_a | input | 1 | Mode pin, first bit |
| mode_b | input | 1 | Mode pin, second bit |
| rst_n_out | output | 1 | Active-low processor reset |
| rst_drive_en | output | 1 | Reset driver enable (0 = high impedance) |
| release_pulse | output | 1 | One-cycle strobe when reset is released |

## Verification
Every output is registered. `rst_drive_en` follows `vout_live` one cycle later. A watchdog request or an output collapse lowers reset one cycle later. A filtered trip lowers reset REACT_TICKS+1 cycles after the drop. Release comes the delay length plus one cycle after the supply turns good. The bench steps a cycle model of the requirements at each rising edge and compares all three outputs at the following falling edge. In the directed cases it counts falling edges from the stimulus to the output change and compares the count with these figures.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2
    } sup_state_e;

    typedef struct packed {
        logic live;
        logic ok;
        logic vin_low;
    } supply_s;

    function automatic logic supply_good(supply_s s);
        return s.live && s.ok && !s.vin_low;
    endfunction

    function automatic logic supply_bad(supply_s s);
        return !s.ok || s.vin_low;
    endfunction

    // only the all-low mode code selects the short delay
    function automatic logic mode_is_slow(logic a, logic b);
        return a || b;
    endfunction

endpackage

// File: rtl/rstgen_glitch_filter.sv
module rstgen_glitch_filter #(
    parameter int REACT_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic bad,
    output logic trip
);
    localparam int FW = $clog2(REACT_TICKS + 1);
    localparam logic [FW-1:0] LIMIT = FW'(REACT_TICKS);

    logic [FW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !bad) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign trip = bad && (cnt_q == LIMIT);

    // R5: the filter never counts past its limit
    p_filter_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

    // R5: a good sample restarts the reaction window
    p_filter_restart_r5: assert property (@(posedge clk) disable iff (rst)
        !bad |=> cnt_q == '0);

endmodule

// File: rtl/rstgen_delay_timer.sv
module rstgen_delay_timer #(
    parameter int FAST_TICKS = 16,
    parameter int SLOW_TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic count_en,
    input  logic tick,
    input  logic slow,
    output logic done
);
    localparam int MAXT = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_TICKS - 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          at_end;

    assign last   = slow ? SLOW_LAST : FAST_LAST;
    assign at_end = cnt_q >= last;
    assign done   = count_en && tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear || done) begin
            cnt_q <= '0;
        end else if (count_en && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the delay count stays inside the longer window
    p_delay_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(MAXT));

    // R11: a clear request empties the count
    p_delay_clear_r11: assert property (@(posedge clk) disable iff (rst)
        clear |=> cnt_q == '0);

endmodule

// File: rtl/rstgen_supervisor.sv
module rstgen_supervisor
    import rstgen_pkg::*;
#(
    parameter int REACT_TICKS = 4,
    parameter int FAST_TICKS  = 16,
    parameter int SLOW_TICKS  = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic vout_live,
    input  logic vout_ok,
    input  logic vin_low,
    input  logic wd_req,
    input  logic mode_a,
    input  logic mode_b,
    output logic rst_n_out,
    output logic rst_drive_en,
    output logic release_pulse
);
    supply_s    sup;
    sup_state_e state_q, state_d;
    logic       good, bad, trip, slow;
    logic       dly_clear, dly_en, dly_done;
    logic       rel_q, en_q;

    assign sup  = '{live: vout_live, ok: vout_ok, vin_low: vin_low};
    assign good = supply_good(sup);
    assign bad  = supply_bad(sup);
    assign slow = mode_is_slow(mode_a, mode_b);

    rstgen_glitch_filter #(
        .REACT_TICKS(REACT_TICKS)
    ) u_filter (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .bad  (bad),
        .trip (trip)
    );

    assign dly_clear = (state_q != ST_DELAY) || wd_req || !good;
    assign dly_en    = (state_q == ST_DELAY) && good && !wd_req;

    rstgen_delay_timer #(
        .FAST_TICKS(FAST_TICKS),
        .SLOW_TICKS(SLOW_TICKS)
    ) u_delay (
        .clk      (clk),
        .rst      (rst),
        .clear    (dly_clear),
        .count_en (dly_en),
        .tick     (tick),
        .slow     (slow),
        .done     (dly_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (good) state_d = ST_DELAY;
            ST_DELAY: begin
                if (!good)         state_d = ST_HOLD;
                else if (dly_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!vout_live || trip) state_d = ST_HOLD;
                else if (wd_req)        state_d = ST_DELAY;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            rel_q   <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            rel_q   <= (state_d == ST_RUN) && (state_q != ST_RUN);
            en_q    <= vout_live;
        end
    end

    assign rst_n_out     = (state_q == ST_RUN);
    assign release_pulse = rel_q;
    assign rst_drive_en  = en_q;

    // R2: a bad supply keeps a low reset low
    p_hold_bad_r2: assert property (@(posedge clk) disable iff (rst)
        (!rst_n_out && (!vout_ok || vin_low)) |=> !rst_n_out);

    // R8: a watchdog request pulls a released reset low
    p_wd_force_r8: assert property (@(posedge clk) disable iff (rst)
        (rst_n_out && wd_req) |=> !rst_n_out);

    // R9: the strobe marks every release
    p_release_mark_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_out) |-> release_pulse);

    // R9: the strobe lasts one cycle
    p_release_single_r9: assert property (@(posedge clk) disable iff (rst)
        release_pulse |=> !release_pulse);

    // R10: output collapse disables the driver and holds reset
    p_collapse_r10: assert property (@(posedge clk) disable iff (rst)
        !vout_live |=> (!rst_n_out && !rst_drive_en));

endmodule

// File: tb/rstgen_supervisor_test.sv
module rstgen_supervisor_test;
    localparam int REACT = 4;
    localparam int FAST  = 16;
    localparam int SLOW  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1, vout_live = 1'b0, vout_ok = 1'b0, vin_low = 1'b0;
    logic wd_req = 1'b0, mode_a = 1'b0, mode_b = 1'b0;
    logic rst_n_out, rst_drive_en, release_pulse;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    rstgen_supervisor #(.REACT_TICKS(REACT), .FAST_TICKS(FAST), .SLOW_TICKS(SLOW)) uut (
        .clk(clk), .rst(rst), .tick(tick), .vout_live(vout_live), .vout_ok(vout_ok),
        .vin_low(vin_low), .wd_req(wd_req), .mode_a(mode_a), .mode_b(mode_b),
        .rst_n_out(rst_n_out), .rst_drive_en(rst_drive_en), .release_pulse(release_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // cycle model built from the requirements
    int  m_state = 0;
    int  m_dcnt = 0, m_fcnt = 0;
    bit  m_rst_n = 0, m_rel = 0, m_en = 0;

    function automatic int lim_of(bit a, bit b);
        return (a || b) ? SLOW : FAST;
    endfunction

    always @(posedge clk) begin
        bit good, bad, trip;
        int nxt;
        cyc++;
        good = vout_live && vout_ok && !vin_low;
        bad  = !vout_ok || vin_low;
        trip = bad && (m_fcnt == REACT);
        if (rst) begin
            m_state = 0; m_dcnt = 0; m_fcnt = 0; m_rst_n = 0; m_rel = 0; m_en = 0;
        end else begin
            nxt = m_state;
            if (m_state == 0) begin
                if (good) begin nxt = 1; m_dcnt = 0; end
            end else if (m_state == 1) begin
                if (!good) begin nxt = 0; m_dcnt = 0; end
                else if (wd_req) m_dcnt = 0;
                else if (tick) begin
                    if (m_dcnt >= lim_of(mode_a, mode_b) - 1) begin nxt = 2; m_dcnt = 0; end
                    else m_dcnt++;
                end
            end else begin
                if (!vout_live || trip) nxt = 0;
                else if (wd_req) begin nxt = 1; m_dcnt = 0; end
            end
            if (!bad) m_fcnt = 0;
            else if (tick && m_fcnt < REACT) m_fcnt++;
            m_rel   = (nxt == 2) && (m_state != 2);
            m_state = nxt;
            m_rst_n = (nxt == 2);
            m_en    = vout_live;
        end
    end

    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R2 model rst_n", rst_n_out, m_rst_n);
            check("R9 model release", release_pulse, m_rel);
            check("R10 model drive_en", rst_drive_en, m_en);
        end
    end

    // count falling edges until rst_n_out reaches the wanted level
    task automatic edges_until(input bit lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_n_out != lvl && n < 200);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wd_pulse();
        wd_req = 1'b1;
        @(negedge clk);
        wd_req = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 rst_n after reset", rst_n_out, 0);
        check("R1 release after reset", release_pulse, 0);
        check("R1 drive_en after reset", rst_drive_en, 0);
        cmp_on = 1;

        vout_live = 1'b1;
        idle(5);
        check("R2 low while below threshold", rst_n_out, 0);
        check("R10 drive_en follows live", rst_drive_en, 1);

        vout_ok = 1'b1;
        edges_until(1'b1, n);
        check("R3 fast release cycles", n, FAST + 1);
        check("R9 strobe at release", release_pulse, 1);
        @(negedge clk);
        check("R9 strobe one cycle", release_pulse, 0);

        // R5: short dips, repeated, do not add up
        vout_ok = 1'b0; idle(REACT); vout_ok = 1'b1; idle(1);
        vout_ok = 1'b0; idle(REACT); vout_ok = 1'b1; idle(3);
        check("R5 short dips ignored", rst_n_out, 1);

        // R6
        vout_ok = 1'b0;
        edges_until(1'b0, n);
        check("R6 trip cycles", n, REACT + 1);
        vout_ok = 1'b1;
        edges_until(1'b1, n);
        check("R3 release after dip", n, FAST + 1);

        // R7
        vin_low = 1'b1;
        edges_until(1'b0, n);
        check("R7 input undervoltage trip", n, REACT + 1);
        vin_low = 1'b0;
        edges_until(1'b1, n);

        // R8
        wd_pulse();
        check("R8 wd forces low", rst_n_out, 0);
        edges_until(1'b1, n);
        check("R8 delay rerun", n + 1, FAST + 1);

        // R4: each slow code
        for (int c = 1; c < 4; c++) begin
            mode_a = c[1]; mode_b = c[0];
            wd_pulse();
            edges_until(1'b1, n);
            check("R4 slow release", n + 1, SLOW + 1);
        end
        mode_a = 1'b0; mode_b = 1'b0;

        // R8: request in the middle of the delay restarts it
        wd_pulse(); idle(5); wd_pulse();
        edges_until(1'b1, n);
        check("R8 restart during delay", n + 1, FAST + 1);

        // R11
        wd_pulse(); idle(5);
        vout_ok = 1'b0; @(negedge clk); vout_ok = 1'b1;
        edges_until(1'b1, n);
        check("R11 delay restart after dip", n, FAST + 1);

        // R10
        vout_live = 1'b0;
        @(negedge clk);
        check("R10 collapse low", rst_n_out, 0);
        check("R10 driver off", rst_drive_en, 0);
        vout_live = 1'b1;
        edges_until(1'b1, n);

        // random phase, checked against the model each cycle
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            tick      = ($urandom_range(0, 3) != 0);
            vout_live = ($urandom_range(0, 99) > 1);
            vout_ok   = ($urandom_range(0, 99) > 6);
            vin_low   = ($urandom_range(0, 99) < 3);
            wd_req    = ($urandom_range(0, 199) == 0);
            if ($urandom_range(0, 499) == 0) begin
                mode_a = $urandom_range(0, 1);
                mode_b = $urandom_range(0, 1);
            end
            @(negedge clk);
        end
        cmp_on = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule